// File: doc/BRIEF.md
# Hardware Task Switch Sequencer

This block runs the control side of a hardware task switch. A requester gives it a switch kind (jump, call, software interrupt or exception, or interrupt return) and a target task selector through a valid/ready handshake. The unit reads the target task-state descriptor's type code and limit over a simple descriptor read port. It classifies the descriptor as 16-bit or 32-bit, and checks that it is available or busy as the kind requires and that its limit is large enough. Once the rest of the machine has exchanged the register context, it marks the descriptor busy through the descriptor write port.

When the switch completes, the unit keeps track of the current task selector, the nested-task flag (NT) and the task-switched flag (TS). It writes the back link into the incoming task segment for calls and interrupts. It reports either completion, optionally with a debug trap, or a single fault vector. It also handles interrupts that do not switch tasks: each one clears NT for the duration of its handler, and NT is restored from a small nesting stack when the handler ends. While TS is set, any coprocessor use is flagged as device-not-available.

States: `ST_IDLE` goes to `ST_READ_DESC` when a request is accepted, or straight to `ST_DONE` for an interrupt return with NT=0. `ST_READ_DESC` goes to `ST_CHECK` on `desc_rd_valid`. `ST_CHECK` goes to `ST_SAVE_WAIT` when the checks pass and to `ST_IDLE` on a fault. `ST_SAVE_WAIT` goes to `ST_MARK` on `ctx_done`. `ST_MARK` stays for a second cycle on a jump or return, then goes to `ST_UPDATE_FLAGS`. `ST_UPDATE_FLAGS` goes to `ST_DONE`, and `ST_DONE` goes to `ST_IDLE`.

Top module: `tsw_ctrl`

## Requirements
- R1: `req_ready` is high only in the idle state, and a request is taken on a cycle where `req_valid` and `req_ready` are both high. `desc_rd` stays high from acceptance until `desc_rd_valid` is seen, and `ctx_start` is low while idle.
- R2: Type codes: 32-bit available 4'h9, 32-bit busy 4'hB, 16-bit available 4'h1, 16-bit busy 4'h3. Any other code gives fault vector 8'd13 and no descriptor write.
- R3: Kind encoding is 0 jump, 1 call, 2 interrupt, 3 return. For kinds 0 to 2 a target already marked busy gives vector 13. For a return, the target (taken from `cur_link`) must be busy; an available one gives vector 13.
- R4: The limit must be strictly greater than 20'h64 for 32-bit and greater than 20'h2B for 16-bit descriptors. Otherwise the unit gives vector 8'd10 and no write. The type checks take priority over the limit check.
- R5: On success the target is written with its format's busy code. For a jump or a return, the next cycle writes the outgoing selector back with its own format's available code. A call or interrupt leaves the outgoing descriptor busy.
- R6: A call or interrupt pulses `link_wr` with `link_sel` = target and `link_data` = outgoing selector, and NT becomes 1. A jump or return makes no link write and loads NT from `ctx_nt`.
- R7: A return while NT=0 completes with no descriptor read, no write and no change of task or flags.
- R8: Each completed switch sets TS, and `ts_clear` clears it. `dev_na` is high exactly when `fpu_use` and TS are both high.
- R9: `dbg_trap` pulses together with `sw_done` if and only if `ctx_trap` was high when `ctx_done` arrived.
- R10: `int_enter` saves NT on a stack of NEST_DEPTH entries and clears NT. `int_exit` restores the most recently saved value.
- R11: `cur_task` takes the target selector when a switch completes, and is unchanged by a fault or a no-op return.
- R12: A fault is a single-cycle `sw_fault` pulse with `fault_vec` valid, and never coincides with `sw_done`. The unit then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Switch request valid |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| req_kind | input | 2 | 0 jump, 1 call, 2 interrupt, 3 return |
| req_sel | input | SEL_W | Target selector (ignored for return) |
| cur_link | input | SEL_W | Back link of the running task |
| desc_rd | output | 1 | Descriptor read request |
| desc_rd_sel | output | SEL_W | Selector to read |
| desc_rd_valid | input | 1 | Read data valid |
| desc_rd_type | input | 4 | Descriptor type code |
| desc_rd_limit | input | LIM_W | Descriptor limit |
| desc_wr | output | 1 | Descriptor type write strobe |
| desc_wr_sel | output | SEL_W | Selector to write |
| desc_wr_type | output | 4 | New type code |
| ctx_start | output | 1 | Context exchange request |
| ctx_done | input | 1 | Context exchange finished |
| ctx_trap | input | 1 | Trap bit of incoming task |
| ctx_nt | input | 1 | NT value saved in incoming task |
| link_wr | output | 1 | Back-link write strobe |
| link_sel | output | SEL_W | Task whose back link is written |
| link_data | output | SEL_W | Back-link value |
| int_enter | input | 1 | Non-switching interrupt handler entry |
| int_exit | input | 1 | Non-switching interrupt handler exit |
| fpu_use | input | 1 | Coprocessor instruction issued |
| ts_clear | input | 1 | Clear TS |
| nt_flag | output | 1 | Nested-task flag |
| ts_flag | output | 1 | Task-switched flag |
| dev_na | output | 1 | Device-not-available exception request |
| cur_task | output | SEL_W | Current task selector |
| sw_done | output | 1 | Switch completed |
| sw_fault | output | 1 | Switch aborted |
| fault_vec | output | 8 | Fault vector (10 or 13) |
| dbg_trap | output | 1 | Debug trap on entry to the new task |

## Verification
If a descriptor is misclassified, it shows at the end of the read cycle plus one: either a `sw_fault` pulse carrying the wrong vector, or a write where none should be. If the state register is wrong, the unit writes the wrong selector or code on the write port within two cycles of `ctx_done`, or it drops or adds the second release write. Corrupted flag state shows on `nt_flag` and `ts_flag` the cycle after `ST_UPDATE_FLAGS`, and on `dev_na` as soon as `fpu_use` is raised. A stale stack shows at the next `int_exit`.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

    typedef enum logic [1:0] {
        KIND_JMP  = 2'd0,
        KIND_CALL = 2'd1,
        KIND_INT  = 2'd2,
        KIND_IRET = 2'd3
    } sw_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_DESC,
        ST_CHECK,
        ST_SAVE_WAIT,
        ST_MARK,
        ST_UPDATE_FLAGS,
        ST_DONE
    } sw_state_e;

    localparam logic [3:0] TY32_FREE = 4'h9;
    localparam logic [3:0] TY32_BUSY = 4'hB;
    localparam logic [3:0] TY16_FREE = 4'h1;
    localparam logic [3:0] TY16_BUSY = 4'h3;

    localparam logic [7:0] VEC_NONE   = 8'd0;
    localparam logic [7:0] VEC_BADTSS = 8'd10;
    localparam logic [7:0] VEC_GP     = 8'd13;

    function automatic logic kind_links(sw_kind_e k);
        return (k == KIND_CALL) || (k == KIND_INT);
    endfunction

    function automatic logic [3:0] free_code(logic is32);
        return is32 ? TY32_FREE : TY16_FREE;
    endfunction

    function automatic logic [3:0] busy_code(logic is32);
        return is32 ? TY32_BUSY : TY16_BUSY;
    endfunction

endpackage

// File: rtl/tsw_desc_check.sv
module tsw_desc_check
    import tsw_pkg::*;
#(
    parameter int              LIM_W = 20,
    parameter logic [LIM_W-1:0] MIN32 = 'h64,
    parameter logic [LIM_W-1:0] MIN16 = 'h2B
) (
    input  sw_kind_e         kind,
    input  logic [3:0]       dtype,
    input  logic [LIM_W-1:0] dlimit,
    output logic             is32,
    output logic             pass,
    output logic [7:0]       vec
);

    logic avail32, busy32, avail16, busy16;
    logic known, is_busy, want_busy, lim_ok;

    always_comb begin
        avail32   = (dtype == TY32_FREE);
        busy32    = (dtype == TY32_BUSY);
        avail16   = (dtype == TY16_FREE);
        busy16    = (dtype == TY16_BUSY);
        known     = avail32 | busy32 | avail16 | busy16;
        is32      = avail32 | busy32;
        is_busy   = busy32 | busy16;
        want_busy = (kind == KIND_IRET);
        lim_ok    = is32 ? (dlimit > MIN32) : (dlimit > MIN16);

        if (!known || (is_busy != want_busy)) begin
            vec = VEC_GP;
        end else if (!lim_ok) begin
            vec = VEC_BADTSS;
        end else begin
            vec = VEC_NONE;
        end
        pass = (vec == VEC_NONE);
    end

endmodule

// File: rtl/tsw_flag_regs.sv
module tsw_flag_regs #(
    parameter int NEST_DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_load,
    input  logic sw_nt,
    input  logic ts_clear,
    input  logic int_enter,
    input  logic int_exit,
    input  logic fpu_use,
    output logic nt,
    output logic ts,
    output logic dev_na
);

    localparam int DW = $clog2(NEST_DEPTH + 1);

    logic [NEST_DEPTH-1:0] stk_q;
    logic [DW-1:0]         depth_q;
    logic                  nt_q, ts_q;
    logic                  do_push, do_pop;

    assign do_push = int_enter && !sw_load;
    assign do_pop  = int_exit && !int_enter && !sw_load && (depth_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nt_q    <= 1'b0;
            depth_q <= '0;
        end else if (sw_load) begin
            nt_q <= sw_nt;
        end else if (do_push) begin
            nt_q <= 1'b0;
            if (depth_q != DW'(NEST_DEPTH)) begin
                depth_q <= depth_q + 1'b1;
            end
        end else if (do_pop) begin
            nt_q    <= stk_q[0];
            depth_q <= depth_q - 1'b1;
        end
    end

    for (genvar g = 0; g < NEST_DEPTH; g++) begin : g_stk
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stk_q[g] <= 1'b0;
            end else if (do_push) begin
                if (g == 0) begin
                    stk_q[g] <= nt_q;
                end else begin
                    stk_q[g] <= stk_q[(g == 0) ? 0 : g-1];
                end
            end else if (do_pop) begin
                if (g == NEST_DEPTH-1) begin
                    stk_q[g] <= 1'b0;
                end else begin
                    stk_q[g] <= stk_q[(g == NEST_DEPTH-1) ? g : g+1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_q <= 1'b0;
        end else if (sw_load) begin
            ts_q <= 1'b1;
        end else if (ts_clear) begin
            ts_q <= 1'b0;
        end
    end

    assign nt     = nt_q;
    assign ts     = ts_q;
    assign dev_na = fpu_use && ts_q;

endmodule

// File: rtl/tsw_ctrl.sv
module tsw_ctrl
    import tsw_pkg::*;
#(
    parameter int               SEL_W      = 16,
    parameter int               LIM_W      = 20,
    parameter int               NEST_DEPTH = 4,
    parameter logic [SEL_W-1:0] RESET_SEL  = 'd1,
    parameter logic             RESET_IS32 = 1'b1,
    parameter logic [LIM_W-1:0] MIN32      = 'h64,
    parameter logic [LIM_W-1:0] MIN16      = 'h2B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic [SEL_W-1:0] req_sel,
    input  logic [SEL_W-1:0] cur_link,
    output logic             desc_rd,
    output logic [SEL_W-1:0] desc_rd_sel,
    input  logic             desc_rd_valid,
    input  logic [3:0]       desc_rd_type,
    input  logic [LIM_W-1:0] desc_rd_limit,
    output logic             desc_wr,
    output logic [SEL_W-1:0] desc_wr_sel,
    output logic [3:0]       desc_wr_type,
    output logic             ctx_start,
    input  logic             ctx_done,
    input  logic             ctx_trap,
    input  logic             ctx_nt,
    output logic             link_wr,
    output logic [SEL_W-1:0] link_sel,
    output logic [SEL_W-1:0] link_data,
    input  logic             int_enter,
    input  logic             int_exit,
    input  logic             fpu_use,
    input  logic             ts_clear,
    output logic             nt_flag,
    output logic             ts_flag,
    output logic             dev_na,
    output logic [SEL_W-1:0] cur_task,
    output logic             sw_done,
    output logic             sw_fault,
    output logic [7:0]       fault_vec,
    output logic             dbg_trap
);

    sw_state_e        state_q, state_d;
    sw_kind_e         kind_q;
    logic [SEL_W-1:0] tgt_q, tr_q;
    logic             tr32_q;
    logic [3:0]       dtype_q;
    logic [LIM_W-1:0] dlim_q;
    logic             trap_q, ctxnt_q, phase_q;

    logic             chk_is32, chk_pass;
    logic [7:0]       chk_vec;
    logic             release_out;
    logic             flag_load, flag_nt;
    logic             accept, noop_ret;

    tsw_desc_check #(
        .LIM_W (LIM_W),
        .MIN32 (MIN32),
        .MIN16 (MIN16)
    ) chk_u (
        .kind   (kind_q),
        .dtype  (dtype_q),
        .dlimit (dlim_q),
        .is32   (chk_is32),
        .pass   (chk_pass),
        .vec    (chk_vec)
    );

    tsw_flag_regs #(
        .NEST_DEPTH (NEST_DEPTH)
    ) flags_u (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_load   (flag_load),
        .sw_nt     (flag_nt),
        .ts_clear  (ts_clear),
        .int_enter (int_enter),
        .int_exit  (int_exit),
        .fpu_use   (fpu_use),
        .nt        (nt_flag),
        .ts        (ts_flag),
        .dev_na    (dev_na)
    );

    assign release_out = (kind_q == KIND_JMP) || (kind_q == KIND_IRET);
    assign accept      = (state_q == ST_IDLE) && req_valid;
    assign noop_ret    = (sw_kind_e'(req_kind) == KIND_IRET) && !nt_flag;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:         if (req_valid) state_d = noop_ret ? ST_DONE : ST_READ_DESC;
            ST_READ_DESC:    if (desc_rd_valid) state_d = ST_CHECK;
            ST_CHECK:        state_d = chk_pass ? ST_SAVE_WAIT : ST_IDLE;
            ST_SAVE_WAIT:    if (ctx_done) state_d = ST_MARK;
            ST_MARK:         state_d = (!phase_q && release_out) ? ST_MARK : ST_UPDATE_FLAGS;
            ST_UPDATE_FLAGS: state_d = ST_DONE;
            ST_DONE:         state_d = ST_IDLE;
            default:         state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request, descriptor and context capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= KIND_JMP;
            tgt_q   <= '0;
            dtype_q <= '0;
            dlim_q  <= '0;
            trap_q  <= 1'b0;
            ctxnt_q <= 1'b0;
            phase_q <= 1'b0;
            tr_q    <= RESET_SEL;
            tr32_q  <= RESET_IS32;
        end else begin
            if (accept) begin
                kind_q  <= sw_kind_e'(req_kind);
                tgt_q   <= (sw_kind_e'(req_kind) == KIND_IRET) ? cur_link : req_sel;
                trap_q  <= 1'b0;
                phase_q <= 1'b0;
            end
            if ((state_q == ST_READ_DESC) && desc_rd_valid) begin
                dtype_q <= desc_rd_type;
                dlim_q  <= desc_rd_limit;
            end
            if ((state_q == ST_SAVE_WAIT) && ctx_done) begin
                trap_q  <= ctx_trap;
                ctxnt_q <= ctx_nt;
            end
            if (state_q == ST_MARK) begin
                phase_q <= 1'b1;
            end
            if (state_q == ST_UPDATE_FLAGS) begin
                tr_q   <= tgt_q;
                tr32_q <= chk_is32;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        desc_rd      = 1'b0;
        desc_wr      = 1'b0;
        desc_wr_sel  = tgt_q;
        desc_wr_type = busy_code(chk_is32);
        ctx_start    = 1'b0;
        link_wr      = 1'b0;
        flag_load    = 1'b0;
        flag_nt      = 1'b0;
        sw_done      = 1'b0;
        sw_fault     = 1'b0;
        fault_vec    = VEC_NONE;
        dbg_trap     = 1'b0;
        unique case (state_q)
            ST_IDLE:      req_ready = 1'b1;
            ST_READ_DESC: desc_rd = 1'b1;
            ST_CHECK: begin
                sw_fault  = !chk_pass;
                fault_vec = chk_vec;
            end
            ST_SAVE_WAIT: ctx_start = 1'b1;
            ST_MARK: begin
                desc_wr = 1'b1;
                if (phase_q) begin
                    desc_wr_sel  = tr_q;
                    desc_wr_type = free_code(tr32_q);
                end
            end
            ST_UPDATE_FLAGS: begin
                link_wr   = kind_links(kind_q);
                flag_load = 1'b1;
                flag_nt   = kind_links(kind_q) ? 1'b1 : ctxnt_q;
            end
            ST_DONE: begin
                sw_done  = 1'b1;
                dbg_trap = trap_q;
            end
            default: ;
        endcase
    end

    assign desc_rd_sel = tgt_q;
    assign link_sel    = tgt_q;
    assign link_data   = tr_q;
    assign cur_task    = tr_q;

endmodule

// File: rtl/tsw_ctrl_chk.sv
module tsw_ctrl_chk #(
    parameter int SEL_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             desc_rd,
    input logic             desc_rd_valid,
    input logic             desc_wr,
    input logic [3:0]       desc_wr_type,
    input logic             ctx_start,
    input logic             link_wr,
    input logic             nt_flag,
    input logic             ts_flag,
    input logic             dev_na,
    input logic [SEL_W-1:0] cur_task,
    input logic             sw_done,
    input logic             sw_fault,
    input logic [7:0]       fault_vec,
    input logic             dbg_trap
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!desc_rd && !ctx_start && !desc_wr)); // R1

    AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_rd && !desc_rd_valid) |=> desc_rd); // R1

    AST_WR_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr |-> (desc_wr_type == 4'h9 || desc_wr_type == 4'hB ||
                     desc_wr_type == 4'h1 || desc_wr_type == 4'h3)); // R2

    AST_FAULT_VEC_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        sw_fault |-> (fault_vec == 8'd10 || fault_vec == 8'd13)); // R4

    AST_FAULT_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        sw_fault |=> (!desc_wr && req_ready)); // R12

    AST_LINK_SETS_NT: assert property (@(posedge clk) disable iff (!rst_n)
        link_wr |=> (nt_flag && ts_flag)); // R6

    AST_NO_TS_NO_DEVNA: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_flag |-> !dev_na); // R8

    AST_TRAP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_trap |-> sw_done); // R9

    AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_done && sw_fault)); // R12

    AST_FAULT_KEEPS_TASK: assert property (@(posedge clk) disable iff (!rst_n)
        sw_fault |=> $stable(cur_task)); // R11

endmodule

bind tsw_ctrl tsw_ctrl_chk #(.SEL_W(SEL_W)) chk_i (.*);

// File: tb/tsw_ctrl_tb_top.sv
`timescale 1ns/1ps
module tsw_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_sel = '0;
    logic [15:0] cur_link = '0;
    logic        desc_rd;
    logic [15:0] desc_rd_sel;
    logic        desc_rd_valid = 1'b0;
    logic [3:0]  desc_rd_type = '0;
    logic [19:0] desc_rd_limit = '0;
    logic        desc_wr;
    logic [15:0] desc_wr_sel;
    logic [3:0]  desc_wr_type;
    logic        ctx_start;
    logic        ctx_done = 1'b0;
    logic        ctx_trap = 1'b0;
    logic        ctx_nt = 1'b0;
    logic        link_wr;
    logic [15:0] link_sel, link_data;
    logic        int_enter = 1'b0, int_exit = 1'b0, fpu_use = 1'b0, ts_clear = 1'b0;
    logic        nt_flag, ts_flag, dev_na;
    logic [15:0] cur_task;
    logic        sw_done, sw_fault, dbg_trap;
    logic [7:0]  fault_vec;

    always #4 clk = ~clk;

    tsw_ctrl dut_i (.*);

    // bench-side descriptor table and context model
    logic [3:0]  tbl_type [32];
    logic [19:0] tbl_lim  [32];
    logic        trap_next = 1'b0, nt_next = 1'b0;
    int          ctx_wait = 0;

    int checks = 0, errors = 0;
    int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, fault_cnt = 0, link_cnt = 0;
    logic [7:0]  last_vec = '0;
    logic        last_trap = 1'b0;
    logic [15:0] last_link_sel = '0, last_link_data = '0;
    bit          finished = 0;

    always @(negedge clk) begin
        if (desc_rd && !desc_rd_valid) begin
            desc_rd_valid = 1'b1;
            desc_rd_type  = tbl_type[desc_rd_sel[4:0]];
            desc_rd_limit = tbl_lim[desc_rd_sel[4:0]];
            rd_cnt++;
        end else begin
            desc_rd_valid = 1'b0;
        end
        if (ctx_start && !ctx_done) begin
            ctx_wait++;
            if (ctx_wait == 2) begin
                ctx_done = 1'b1;
                ctx_trap = trap_next;
                ctx_nt   = nt_next;
                ctx_wait = 0;
            end
        end else begin
            ctx_done = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (desc_wr) begin
                tbl_type[desc_wr_sel[4:0]] = desc_wr_type;
                wr_cnt++;
            end
            if (sw_fault) begin
                fault_cnt++;
                last_vec = fault_vec;
            end
            if (sw_done) begin
                done_cnt++;
                last_trap = dbg_trap;
            end
            if (link_wr) begin
                link_cnt++;
                last_link_sel  = link_sel;
                last_link_data = link_data;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_switch(input logic [1:0] kind, input logic [15:0] sel);
        int d0, f0;
        d0 = done_cnt;
        f0 = fault_cnt;
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = kind;
        req_sel   = sel;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (done_cnt != d0 || fault_cnt != f0) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(ts_flag == 1'b0 && nt_flag == 1'b0, "R8 flags after reset", {ts_flag, nt_flag}, 0);
        chk(cur_task == 16'd1, "R11 reset task", cur_task, 1);
        chk(desc_rd == 1'b0 && ctx_start == 1'b0, "R1 idle quiet", {desc_rd, ctx_start}, 0);
    endtask

    task automatic t_jump;
        int w0 = wr_cnt, l0 = link_cnt, d0 = done_cnt;
        trap_next = 1'b0; nt_next = 1'b0;
        do_switch(2'd0, 16'd2);
        chk(done_cnt == d0 + 1, "R5 jump completes", done_cnt - d0, 1);
        chk(tbl_type[2] == 4'hB, "R5 jump target busy", tbl_type[2], 4'hB);
        chk(tbl_type[1] == 4'h9, "R5 jump releases outgoing", tbl_type[1], 4'h9);
        chk(wr_cnt == w0 + 2, "R5 jump two writes", wr_cnt - w0, 2);
        chk(link_cnt == l0, "R6 jump no link", link_cnt - l0, 0);
        chk(nt_flag == 1'b0, "R6 jump nt from ctx", nt_flag, 0);
        chk(ts_flag == 1'b1, "R8 ts set by switch", ts_flag, 1);
        chk(cur_task == 16'd2, "R11 jump task", cur_task, 2);
        chk(last_trap == 1'b0, "R9 no trap", last_trap, 0);
    endtask

    task automatic t_call;
        int w0;
        @(negedge clk); ts_clear = 1'b1;
        @(negedge clk); ts_clear = 1'b0; fpu_use = 1'b1;
        #1;
        chk(ts_flag == 1'b0, "R8 ts cleared", ts_flag, 0);
        chk(dev_na == 1'b0, "R8 no devna when ts clear", dev_na, 0);
        fpu_use = 1'b0;
        w0 = wr_cnt;
        trap_next = 1'b1; nt_next = 1'b0;
        do_switch(2'd1, 16'd3);
        chk(tbl_type[3] == 4'h3, "R5 call 16-bit busy", tbl_type[3], 4'h3);
        chk(tbl_type[2] == 4'hB, "R5 call keeps outgoing busy", tbl_type[2], 4'hB);
        chk(wr_cnt == w0 + 1, "R5 call one write", wr_cnt - w0, 1);
        chk(last_link_sel == 16'd3 && last_link_data == 16'd2, "R6 call back link",
            {last_link_sel, last_link_data}, {16'd3, 16'd2});
        chk(nt_flag == 1'b1, "R6 call sets nt", nt_flag, 1);
        chk(last_trap == 1'b1, "R9 trap raised", last_trap, 1);
        @(negedge clk); fpu_use = 1'b1; #1;
        chk(dev_na == 1'b1, "R8 devna with ts", dev_na, 1);
        @(negedge clk); fpu_use = 1'b0;
        trap_next = 1'b0;
    endtask

    task automatic t_iret;
        int w0 = wr_cnt;
        cur_link = 16'd2; nt_next = 1'b0;
        do_switch(2'd3, 16'd0);
        chk(tbl_type[2] == 4'hB, "R3 return target stays busy", tbl_type[2], 4'hB);
        chk(tbl_type[3] == 4'h1, "R5 return releases 16-bit", tbl_type[3], 4'h1);
        chk(wr_cnt == w0 + 2, "R5 return two writes", wr_cnt - w0, 2);
        chk(cur_task == 16'd2, "R11 return task", cur_task, 2);
        chk(nt_flag == 1'b0, "R6 return nt from ctx", nt_flag, 0);
    endtask

    task automatic t_noop_ret;
        int r0 = rd_cnt, w0 = wr_cnt, d0 = done_cnt;
        do_switch(2'd3, 16'd0);
        chk(done_cnt == d0 + 1, "R7 noop return done", done_cnt - d0, 1);
        chk(rd_cnt == r0 && wr_cnt == w0, "R7 noop no access", rd_cnt - r0 + wr_cnt - w0, 0);
        chk(cur_task == 16'd2, "R7 noop task kept", cur_task, 2);
    endtask

    task automatic t_fault(input logic [1:0] kind, input logic [15:0] sel,
                           input logic [7:0] vec, input string tag);
        int w0 = wr_cnt, f0 = fault_cnt;
        logic [3:0] ty0 = tbl_type[sel[4:0]];
        logic [15:0] c0 = cur_task;
        do_switch(kind, sel);
        chk(fault_cnt == f0 + 1, {tag, " fault raised"}, fault_cnt - f0, 1);
        chk(last_vec == vec, {tag, " vector"}, last_vec, vec);
        chk(wr_cnt == w0 && tbl_type[sel[4:0]] == ty0, {tag, " no write"}, wr_cnt - w0, 0);
        chk(cur_task == c0, "R11 fault keeps task", cur_task, c0);
    endtask

    task automatic t_faults;
        t_fault(2'd0, 16'd4, 8'd10, "R4 32-bit limit at 0x64");
        t_fault(2'd0, 16'd5, 8'd10, "R4 16-bit limit at 0x2B");
        t_fault(2'd0, 16'd6, 8'd13, "R3 busy target");
        t_fault(2'd0, 16'd7, 8'd13, "R2 unknown type");
        t_fault(2'd0, 16'd9, 8'd13, "R4 type beats limit");
    endtask

    task automatic t_int_boundary;
        int w0 = wr_cnt;
        do_switch(2'd2, 16'd8);
        chk(tbl_type[8] == 4'hB, "R4 limit 0x65 accepted", tbl_type[8], 4'hB);
        chk(wr_cnt == w0 + 1, "R5 int one write", wr_cnt - w0, 1);
        chk(nt_flag == 1'b1, "R6 int sets nt", nt_flag, 1);
        chk(last_link_data == 16'd2, "R6 int back link", last_link_data, 2);
        cur_link = 16'd3;
        t_fault(2'd3, 16'd0, 8'd13, "R3 return to available");
    endtask

    task automatic t_nest;
        @(negedge clk); int_enter = 1'b1;
        @(negedge clk); int_enter = 1'b0;
        chk(nt_flag == 1'b0, "R10 enter clears nt", nt_flag, 0);
        @(negedge clk); int_enter = 1'b1;
        @(negedge clk); int_enter = 1'b0; int_exit = 1'b1;
        @(negedge clk); int_exit = 1'b0;
        chk(nt_flag == 1'b0, "R10 inner exit restores 0", nt_flag, 0);
        @(negedge clk); int_exit = 1'b1;
        @(negedge clk); int_exit = 1'b0;
        chk(nt_flag == 1'b1, "R10 outer exit restores 1", nt_flag, 1);
    endtask

    task automatic t_final_ret;
        cur_link = 16'd2; nt_next = 1'b1;
        do_switch(2'd3, 16'd0);
        chk(tbl_type[8] == 4'h9, "R5 return frees 32-bit", tbl_type[8], 4'h9);
        chk(nt_flag == 1'b1, "R6 return loads ctx nt", nt_flag, 1);
        chk(cur_task == 16'd2, "R11 final task", cur_task, 2);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            tbl_type[i] = 4'h0;
            tbl_lim[i]  = 20'h0;
        end
        tbl_type[1] = 4'hB; tbl_lim[1] = 20'h67;
        tbl_type[2] = 4'h9; tbl_lim[2] = 20'h67;
        tbl_type[3] = 4'h1; tbl_lim[3] = 20'h2C;
        tbl_type[4] = 4'h9; tbl_lim[4] = 20'h64;
        tbl_type[5] = 4'h1; tbl_lim[5] = 20'h2B;
        tbl_type[6] = 4'hB; tbl_lim[6] = 20'h67;
        tbl_type[7] = 4'h5; tbl_lim[7] = 20'h67;
        tbl_type[8] = 4'h9; tbl_lim[8] = 20'h65;
        tbl_type[9] = 4'hC; tbl_lim[9] = 20'h10;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_jump();
        t_call();
        t_iret();
        t_noop_ret();
        t_faults();
        t_int_boundary();
        t_nest();
        t_final_ret();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule